// File: doc/BRIEF.md
# Single-Bit Set, Clear and Test Unit

This block modifies or inspects exactly one bit of a byte-wide operand. A bit index picks the position and a two-bit operation code chooses between forcing that bit high, forcing it low, or testing it. The block is purely combinational. Its outputs are the new operand value, a write-enable that tells the surrounding datapath whether to store that value back, and the updated flag byte.

The operand can be the accumulator, a general register, or a memory byte fetched through register-indirect or indexed addressing. The surrounding core fetches the operand and stores the result. This unit handles every source in the same way. Every combination of bit index and operation gives a defined result, so every opcode in the bit-manipulation group maps onto the same three select inputs.

Top module: `bitop_unit`

## Requirements
- R1: When the operation code is 2'b10 (set), the result equals the operand with the bit at the given index forced to 1, and the write-enable is 1.
- R2: When the operation code is 2'b01 (clear), the result equals the operand with the bit at the given index forced to 0, every other bit is unchanged, and the write-enable is 1.
- R3: On set and clear, the output flag byte equals the input flag byte.
- R4: When the operation code is 2'b00 (test), the write-enable is 0 and the result equals the operand.
- R5: On test, flag bit 6 (zero) becomes 1 if the selected operand bit is 0, and becomes 0 if that bit is 1.
- R6: On test, flag bit 4 (half-carry) becomes 1 and flag bit 1 (subtract) becomes 0. Flag bit 0 (carry) and flag bits 7, 5, 3 and 2 keep their input values.
- R7: Operation code 2'b11 is reserved. It gives a write-enable of 0, a result equal to the operand, and an output flag byte equal to the input flag byte.
- R8: The block holds no state. Its outputs depend only on the present inputs and follow any input change within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte from register or memory |
| bit_sel_i | input | 3 | Index of the bit to act on (0 = LSB) |
| op_i | input | 2 | 00 test, 01 clear, 10 set, 11 reserved |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | Operand after the operation |
| wr_en_o | output | 1 | 1 when the result must be written back |
| flags_o | output | 8 | Flag byte after the operation |

## Verification
The block holds no state, so any fault in the index decoder or in the operation steering shows at the ports in the same cycle as the inputs that trigger it. A wrong one-hot mask changes either a neighbouring bit of the result or the zero flag on a test. A wrong operation decode shows as a write-enable of the wrong polarity, or as flag bits that move when they should hold. The bench runs through all bit indices and all four operation codes, using edge-case operands and random operands, and compares every output in each cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = $clog2(DATA_W);
    localparam int FLAG_W = 8;

    // flag byte positions used by the test operation
    localparam int FLG_C = 0;
    localparam int FLG_N = 1;
    localparam int FLG_H = 4;
    localparam int FLG_Z = 6;

    typedef enum logic [1:0] {
        OP_TEST = 2'b00,
        OP_CLR  = 2'b01,
        OP_SET  = 2'b10,
        OP_RSV  = 2'b11
    } bitop_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              wr_en;
    } wb_t;

    function automatic logic is_modify(input bitop_e op);
        return (op == OP_SET) || (op == OP_CLR);
    endfunction

endpackage

// File: rtl/bitop_mask_dec.sv
module bitop_mask_dec #(
    parameter int DATA_W = bitop_pkg::DATA_W,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] mask_o
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign mask_o[g] = (sel_i == SEL_W'(g));
    end
endmodule

// File: rtl/bitop_apply.sv
module bitop_apply
    import bitop_pkg::*;
#(
    parameter int DATA_W = bitop_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] mask_i,
    input  bitop_e            op_i,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_en_o
);
    always_comb begin
        unique case (op_i)
            OP_SET:  data_o = opnd_i | mask_i;
            OP_CLR:  data_o = opnd_i & ~mask_i;
            default: data_o = opnd_i;
        endcase
        wr_en_o = is_modify(op_i);
    end
endmodule

// File: rtl/bitop_flags.sv
module bitop_flags
    import bitop_pkg::*;
#(
    parameter int DATA_W = bitop_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] mask_i,
    input  bitop_e            op_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic picked;

    always_comb begin
        picked  = |(opnd_i & mask_i);
        flags_o = flags_i;
        if (op_i == OP_TEST) begin
            flags_o[FLG_Z] = ~picked;
            flags_o[FLG_H] = 1'b1;
            flags_o[FLG_N] = 1'b0;
        end
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = bitop_pkg::DATA_W,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic [1:0]        op_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [DATA_W-1:0] mask;
    bitop_e            op;
    wb_t               wb;

    assign op = bitop_e'(op_i);

    bitop_mask_dec #(.DATA_W(DATA_W)) u_dec (
        .sel_i  (bit_sel_i),
        .mask_o (mask)
    );

    bitop_apply #(.DATA_W(DATA_W)) u_apply (
        .opnd_i  (opnd_i),
        .mask_i  (mask),
        .op_i    (op),
        .data_o  (wb.data),
        .wr_en_o (wb.wr_en)
    );

    bitop_flags #(.DATA_W(DATA_W)) u_flags (
        .opnd_i  (opnd_i),
        .mask_i  (mask),
        .op_i    (op),
        .flags_i (flags_i),
        .flags_o (flags_o)
    );

    assign result_o = wb.data;
    assign wr_en_o  = wb.wr_en;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
    import bitop_pkg::*;
#(
    parameter int DATA_W = bitop_pkg::DATA_W,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] opnd_i,
    input logic [SEL_W-1:0]  bit_sel_i,
    input logic [1:0]        op_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic [DATA_W-1:0] diff;
    logic [FLAG_W-1:0] fdiff;

    always_comb begin
        diff  = result_o ^ opnd_i;
        fdiff = flags_o ^ flags_i;
        if (op_i == 2'b10) begin
            assert_set_bit_R1: assert (result_o[bit_sel_i] && wr_en_o &&
                                       $countones(diff) <= 1);
        end
        if (op_i == 2'b01) begin
            assert_clr_bit_R2: assert (!result_o[bit_sel_i] && wr_en_o &&
                                       $countones(diff) <= 1);
        end
        if (op_i == 2'b10 || op_i == 2'b01) begin
            assert_flags_hold_R3: assert (fdiff == '0);
        end
        if (op_i == 2'b00) begin
            assert_test_nowrite_R4: assert (!wr_en_o && diff == '0);
            assert_test_zero_R5: assert (flags_o[FLG_Z] != opnd_i[bit_sel_i]);
            assert_test_hn_R6: assert (flags_o[FLG_H] && !flags_o[FLG_N] &&
                                       (fdiff & 8'b1010_1101) == '0);
        end
        if (op_i == 2'b11) begin
            assert_rsv_inert_R7: assert (!wr_en_o && diff == '0 && fdiff == '0);
        end
    end
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd;
    logic [2:0] sel;
    logic [1:0] op;
    logic [7:0] flg;
    logic [7:0] res;
    logic       we;
    logic [7:0] flg_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bitop_unit dut_i (
        .opnd_i    (opnd),
        .bit_sel_i (sel),
        .op_i      (op),
        .flags_i   (flg),
        .result_o  (res),
        .wr_en_o   (we),
        .flags_o   (flg_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (op=%0d sel=%0d opnd=%0h flags=%0h)",
                     req, act, exp, op, sel, opnd, flg);
        end
    endtask

    // behavioural reference, compared once per cycle
    task automatic apply_and_check(logic [7:0] a, int idx, int code, logic [7:0] f);
        logic [7:0] e_res;
        logic [7:0] e_flg;
        int         e_we;
        @(posedge clk);
        opnd = a; sel = 3'(idx); op = 2'(code); flg = f;
        e_res = a; e_flg = f; e_we = 0;
        case (code)
            2: begin e_res = a | (8'd1 << idx); e_we = 1; end
            1: begin e_res = a & ~(8'd1 << idx); e_we = 1; end
            0: begin
                e_flg[6] = (((a >> idx) & 8'd1) == 8'd0);
                e_flg[4] = 1'b1;
                e_flg[1] = 1'b0;
            end
            default: ;
        endcase
        @(negedge clk);
        case (code)
            2: begin check("R1 result", res, e_res); check("R1 wr_en", we, e_we);
                     check("R3 flags", flg_out, e_flg); end
            1: begin check("R2 result", res, e_res); check("R2 wr_en", we, e_we);
                     check("R3 flags", flg_out, e_flg); end
            0: begin check("R4 result", res, e_res); check("R4 wr_en", we, e_we);
                     check("R5 zero", flg_out[6], e_flg[6]);
                     check("R6 flags", flg_out, e_flg); end
            default: begin check("R7 result", res, e_res); check("R7 wr_en", we, e_we);
                     check("R7 flags", flg_out, e_flg); end
        endcase
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        opnd = '0; sel = '0; op = '0; flg = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: zero inputs select a test of bit 0 on a zero operand
        @(negedge clk);
        check("R4 idle wr_en", we, 0);
        check("R4 idle result", res, 0);
        check("R5 idle flags", flg_out, 8'h50);
        // R8: output follows an input change within the same cycle
        @(posedge clk); op = 2'b10; sel = 3'd7; opnd = 8'h00;
        #1 check("R8 same-cycle", res, 8'h80);
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 8; i++)
                for (int c = 0; c < 4; c++) begin
                    apply_and_check(pats[p], i, c, 8'h00);
                    apply_and_check(pats[p], i, c, 8'hFF);
                end
        for (int n = 0; n < 400; n++)
            apply_and_check(8'($urandom), int'($urandom_range(0, 7)),
                            int'($urandom_range(0, 3)), 8'($urandom));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule